// File: doc/BRIEF.md
# Banked Pointer-Register RAM Addresser

This block turns operand-access requests of a small DSP core into data-RAM read addresses. The core has two RAM banks and eight 8-bit pointer registers. Pointers 0 to 3 address bank 0 and pointers 4 to 7 address bank 1. In each bank the last pointer (3 and 7) is tied to word 0 of its bank and reaches only the first four words, through a 2-bit short offset. The other six pointers can be loaded with an immediate value and can be stepped after use.

A request names a pointer, an addressing mode, a modifier and a short offset. The block presents the resulting access on an output stream: the bank, the address, whether a RAM read is needed, and which step of a two-step fetch it is. In direct mode the pointer value itself is the operand and no RAM read is needed. Single indirection reads the word at the pointer. Double indirection makes two reads. The block waits for the first read's data on the RAM return port and then issues a second read in the same bank at that data value. The RAM arrays are outside the block.

Both the request stream and the access stream use valid/ready. A request is taken only when `req_valid` and `req_ready` are both high. The access output holds `acc_valid` and all of its fields steady until `acc_ready` is sampled high. While the access output is stalled, or a double fetch is in progress, `req_ready` stays low. Loads, the RAM return, `busy` and `err` are plain signals.

Top module: `ptr_ram_addresser`

## Requirements
- R1: After reset every writable pointer reads 0, `acc_valid`, `busy` and `err` are 0, and `req_ready` is 1.
- R2: Bit 2 of the pointer index selects the bank: pointers 0 to 3 give `acc_bank`=0 and pointers 4 to 7 give `acc_bank`=1.
- R3: For a writable pointer, `req_mode`=0 (direct) gives `acc_mem`=0 with `acc_addr` equal to the pointer value. `req_mode`=1 (single) and `req_mode`=3 (short) give `acc_mem`=1 with `acc_addr` equal to the pointer value.
- R4: For pointers 3 and 7, `acc_addr` is `req_ofs` zero-extended and `acc_mem`=1 in modes 0, 1 and 3, and the modifier has no effect.
- R5: `req_mod` codes: 0 leaves the pointer unchanged, 1 and 3 add one, and 2 subtracts one, modulo 256. The issued address uses the value before the change.
- R6: `req_mode`=2 (double) first issues `acc_step`=0 at the base address. After that handshake the block waits for `ram_rvalid`. It then issues `acc_step`=1 with `acc_addr`=`ram_rdata` in the same bank.
- R7: `ld_en` writes `ld_val` into a writable pointer at the next edge. A load aimed at pointer 3 or 7 changes nothing and sets `err`, which stays set until reset.
- R8: While `acc_valid` is high and `acc_ready` is low, the access fields stay stable and `req_ready` is low.
- R9: `busy` is high from the acceptance of a double request until its second access is taken. `req_ready` is low while `busy` is high. `ram_rvalid` outside the wait for a first read's data is ignored.
- R10: When a load and a post-modification hit the same pointer in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_ptr | input | 3 | Pointer index |
| req_mode | input | 2 | 0 direct, 1 single, 2 double, 3 short |
| req_mod | input | 2 | 0 none, 1 increment, 2 decrement, 3 increment |
| req_ofs | input | 2 | Short offset for pointers 3 and 7 |
| ld_en | input | 1 | Immediate load strobe |
| ld_ptr | input | 3 | Pointer to load |
| ld_val | input | 8 | Value to load |
| acc_valid | output | 1 | Access present |
| acc_ready | input | 1 | Consumer takes the access |
| acc_bank | output | 1 | RAM bank |
| acc_addr | output | 8 | Address or pointer value |
| acc_mem | output | 1 | 1 when a RAM read is needed |
| acc_step | output | 1 | 1 for the second read of a double fetch |
| ram_rvalid | input | 1 | RAM read data valid |
| ram_rdata | input | 8 | RAM read data |
| busy | output | 1 | Double fetch in progress |
| err | output | 1 | Sticky flag for a load aimed at a fixed pointer |

## Verification
A pointer holding a wrong value shows up at the ports on the next access through it. A direct-mode read shows the value itself one cycle after acceptance, so post-modification, wrap-around and load errors appear within two cycles of the access that caused them. A sequencer stuck in the wrong state shows within a cycle as `busy` stuck high, a second access that never comes, or a changing address while the output is stalled. A second access in the wrong bank also appears within a cycle. A load that wrongly reaches a fixed pointer shows as a nonzero short-offset address on the next short access.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_SINGLE = 2'd1,
    AM_DOUBLE = 2'd2,
    AM_SHORT  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_INCB = 2'd3
  } pmod_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FIRST  = 2'd1,
    SQ_WAIT   = 2'd2,
    SQ_SECOND = 2'd3
  } seq_e;
endpackage

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_addr_pkg::*;
#(
  parameter int NPTR  = 8,
  parameter int PTR_W = 8,
  localparam int IDX_W = $clog2(NPTR),
  localparam int BANK_N = NPTR / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             mod_en,
  input  logic [IDX_W-1:0] mod_idx,
  input  pmod_e            mod_code,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PTR_W-1:0] rd_val,
  output logic             err
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] ptr_w [NPTR];

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    localparam bit FIXED = ((gi % BANK_N) == (BANK_N - 1));
    if (FIXED) begin : g_fixed
      assign ptr_w[gi] = '0;
    end else begin : g_live
      logic [PTR_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= '0;
        end else if (ld_en && (ld_idx == IDX_W'(gi))) begin
          q <= ld_val;
        end else if (mod_en && (mod_idx == IDX_W'(gi))) begin
          case (mod_code)
            PM_INC, PM_INCB: q <= q + ONE;
            PM_DEC:          q <= q - ONE;
            default:         q <= q;
          endcase
        end
      end
      assign ptr_w[gi] = q;
    end
  end

  assign rd_val = ptr_w[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if (ld_en && (&ld_idx[IDX_W-2:0])) err <= 1'b1;
  end
endmodule

// File: rtl/ptr_ea.sv
module ptr_ea
  import ptr_addr_pkg::*;
#(
  parameter int NPTR  = 8,
  parameter int PTR_W = 8,
  parameter int OFS_W = 2,
  localparam int IDX_W = $clog2(NPTR)
) (
  input  logic [IDX_W-1:0] idx,
  input  amode_e           mode,
  input  logic [OFS_W-1:0] ofs,
  input  logic [PTR_W-1:0] ptr_val,
  output logic             bank,
  output logic [PTR_W-1:0] addr,
  output logic             mem,
  output logic             dbl
);
  logic fixed;

  always_comb begin
    fixed = &idx[IDX_W-2:0];
    bank  = idx[IDX_W-1];
    dbl   = (mode == AM_DOUBLE);
    if (fixed) begin
      addr = {{(PTR_W-OFS_W){1'b0}}, ofs};
      mem  = 1'b1;
    end else begin
      addr = ptr_val;
      mem  = (mode != AM_DIRECT);
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import ptr_addr_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             accept,
  input  logic             ea_bank,
  input  logic [PTR_W-1:0] ea_addr,
  input  logic             ea_mem,
  input  logic             ea_dbl,
  output logic             acc_valid,
  input  logic             acc_ready,
  output logic             acc_bank,
  output logic [PTR_W-1:0] acc_addr,
  output logic             acc_mem,
  output logic             acc_step,
  input  logic             ram_rvalid,
  input  logic [PTR_W-1:0] ram_rdata,
  output logic             busy
);
  seq_e st;

  assign req_ready = (st == SQ_IDLE) && (!acc_valid || acc_ready);
  assign accept    = req_valid && req_ready;
  assign busy      = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      acc_valid <= 1'b0;
      acc_bank  <= 1'b0;
      acc_addr  <= '0;
      acc_mem   <= 1'b0;
      acc_step  <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (accept) begin
            acc_valid <= 1'b1;
            acc_bank  <= ea_bank;
            acc_addr  <= ea_addr;
            acc_mem   <= ea_mem | ea_dbl;
            acc_step  <= 1'b0;
            st        <= ea_dbl ? SQ_FIRST : SQ_IDLE;
          end else if (acc_valid && acc_ready) begin
            acc_valid <= 1'b0;
          end
        end
        SQ_FIRST: begin
          if (acc_ready) begin
            acc_valid <= 1'b0;
            st        <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (ram_rvalid) begin
            acc_valid <= 1'b1;
            acc_addr  <= ram_rdata;
            acc_mem   <= 1'b1;
            acc_step  <= 1'b1;
            st        <= SQ_SECOND;
          end
        end
        default: begin
          if (acc_ready) begin
            acc_valid <= 1'b0;
            acc_step  <= 1'b0;
            st        <= SQ_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ptr_ram_addresser.sv
module ptr_ram_addresser
  import ptr_addr_pkg::*;
#(
  parameter int NPTR  = 8,
  parameter int PTR_W = 8,
  parameter int OFS_W = 2,
  localparam int IDX_W = $clog2(NPTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_ptr,
  input  logic [1:0]       req_mode,
  input  logic [1:0]       req_mod,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_ptr,
  input  logic [PTR_W-1:0] ld_val,
  output logic             acc_valid,
  input  logic             acc_ready,
  output logic             acc_bank,
  output logic [PTR_W-1:0] acc_addr,
  output logic             acc_mem,
  output logic             acc_step,
  input  logic             ram_rvalid,
  input  logic [PTR_W-1:0] ram_rdata,
  output logic             busy,
  output logic             err
);
  logic [PTR_W-1:0] ptr_val;
  logic             ea_bank, ea_mem, ea_dbl, accept;
  logic [PTR_W-1:0] ea_addr;

  ptr_regfile #(.NPTR(NPTR), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_ptr), .ld_val(ld_val),
    .mod_en(accept), .mod_idx(req_ptr), .mod_code(pmod_e'(req_mod)),
    .rd_idx(req_ptr), .rd_val(ptr_val), .err(err)
  );

  ptr_ea #(.NPTR(NPTR), .PTR_W(PTR_W), .OFS_W(OFS_W)) u_ea (
    .idx(req_ptr), .mode(amode_e'(req_mode)), .ofs(req_ofs),
    .ptr_val(ptr_val), .bank(ea_bank), .addr(ea_addr),
    .mem(ea_mem), .dbl(ea_dbl)
  );

  fetch_seq #(.PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .accept(accept),
    .ea_bank(ea_bank), .ea_addr(ea_addr), .ea_mem(ea_mem), .ea_dbl(ea_dbl),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_bank(acc_bank),
    .acc_addr(acc_addr), .acc_mem(acc_mem), .acc_step(acc_step),
    .ram_rvalid(ram_rvalid), .ram_rdata(ram_rdata), .busy(busy)
  );
endmodule

// File: rtl/ptr_addr_checker.sv
module ptr_addr_checker #(
  parameter int NPTR  = 8,
  parameter int PTR_W = 8,
  parameter int OFS_W = 2,
  localparam int IDX_W = $clog2(NPTR)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] req_ptr,
  input logic [OFS_W-1:0] req_ofs,
  input logic [1:0]       req_mode,
  input logic             ld_en,
  input logic [IDX_W-1:0] ld_ptr,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_bank,
  input logic [PTR_W-1:0] acc_addr,
  input logic             acc_mem,
  input logic             acc_step,
  input logic             busy,
  input logic             err
);
  logic first_bank;
  always_ff @(posedge clk) begin
    if (!rst_n) first_bank <= 1'b0;
    else if (acc_valid && acc_ready && !acc_step) first_bank <= acc_bank;
  end

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_hold_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) &&
    $stable(acc_bank) && $stable(acc_step) && $stable(acc_mem));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_fixed_load_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && (&ld_ptr[IDX_W-2:0]) |=> err);

  assert_second_same_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_step |-> acc_mem && busy && (acc_bank == first_bank));

  assert_fixed_short_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (&req_ptr[IDX_W-2:0]) && (req_mode != 2'd2) |=>
    acc_valid && acc_mem && (acc_addr == {{(PTR_W-OFS_W){1'b0}}, $past(req_ofs)}));

  assert_bank_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> acc_bank == $past(req_ptr[IDX_W-1]));
endmodule

bind ptr_ram_addresser ptr_addr_checker #(.NPTR(NPTR), .PTR_W(PTR_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ptr(req_ptr), .req_ofs(req_ofs), .req_mode(req_mode),
  .ld_en(ld_en), .ld_ptr(ld_ptr),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_bank(acc_bank),
  .acc_addr(acc_addr), .acc_mem(acc_mem), .acc_step(acc_step),
  .busy(busy), .err(err)
);

// File: tb/ptr_ram_addresser_bench.sv
module ptr_ram_addresser_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_ptr = '0;
  logic [1:0] req_mode = '0;
  logic [1:0] req_mod = '0;
  logic [1:0] req_ofs = '0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_ptr = '0;
  logic [7:0] ld_val = '0;
  logic       acc_valid, acc_bank, acc_mem, acc_step;
  logic [7:0] acc_addr;
  logic       acc_ready = 1'b1;
  logic       ram_rvalid = 1'b0;
  logic [7:0] ram_rdata = '0;
  logic       busy, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptr_ram_addresser u_ptr_ram_addresser (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ptr(req_ptr), .req_mode(req_mode), .req_mod(req_mod), .req_ofs(req_ofs),
    .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_val(ld_val),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_bank(acc_bank),
    .acc_addr(acc_addr), .acc_mem(acc_mem), .acc_step(acc_step),
    .ram_rvalid(ram_rvalid), .ram_rdata(ram_rdata), .busy(busy), .err(err)
  );

  // vector: {ptr[3], mode[2], mod[2], ofs[2], bank, addr[8], mem}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 2'd1, 2'd1, 2'd0, 1'b0, 8'h10, 1'b1},
    {3'd0, 2'd1, 2'd0, 2'd0, 1'b0, 8'h11, 1'b1},
    {3'd1, 2'd1, 2'd1, 2'd0, 1'b0, 8'hFF, 1'b1},
    {3'd1, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0},
    {3'd2, 2'd1, 2'd2, 2'd0, 1'b0, 8'h00, 1'b1},
    {3'd2, 2'd0, 2'd3, 2'd0, 1'b0, 8'hFF, 1'b0},
    {3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0},
    {3'd3, 2'd3, 2'd1, 2'd2, 1'b0, 8'h02, 1'b1},
    {3'd7, 2'd1, 2'd0, 2'd3, 1'b1, 8'h03, 1'b1},
    {3'd7, 2'd0, 2'd2, 2'd1, 1'b1, 8'h01, 1'b1},
    {3'd4, 2'd3, 2'd2, 2'd0, 1'b1, 8'h80, 1'b1},
    {3'd4, 2'd0, 2'd0, 2'd0, 1'b1, 8'h7F, 1'b0},
    {3'd5, 2'd1, 2'd3, 2'd0, 1'b1, 8'h01, 1'b1},
    {3'd5, 2'd0, 2'd0, 2'd0, 1'b1, 8'h02, 1'b0},
    {3'd6, 2'd1, 2'd2, 2'd0, 1'b1, 8'h7F, 1'b1},
    {3'd6, 2'd0, 2'd0, 2'd0, 1'b1, 8'h7E, 1'b0},
    {3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // access word: {valid, bank, addr, mem, step}
  function automatic logic [31:0] accw();
    return {20'd0, acc_valid, acc_bank, acc_addr, acc_mem, acc_step};
  endfunction

  function automatic logic [31:0] mk(input logic b, input logic [7:0] a,
                                     input logic m, input logic s);
    return {20'd0, 1'b1, b, a, m, s};
  endfunction

  task automatic do_req(input logic [2:0] p, input logic [1:0] md,
                        input logic [1:0] mf, input logic [1:0] of);
    @(negedge clk);
    req_valid = 1'b1; req_ptr = p; req_mode = md; req_mod = mf; req_ofs = of;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [2:0] p, input logic [7:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_ptr = p; ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {28'd0, acc_valid, busy, err, req_ready}, 32'h1);
    do_req(3'd0, 2'd0, 2'd0, 2'd0);
    chk("R1 ptr0 zero", accw(), mk(1'b0, 8'h00, 1'b0, 1'b0));
    do_req(3'd6, 2'd0, 2'd0, 2'd0);
    chk("R1 ptr6 zero", accw(), mk(1'b1, 8'h00, 1'b0, 1'b0));

    // R7 loads to writable pointers
    do_load(3'd0, 8'h10); do_load(3'd1, 8'hFF); do_load(3'd2, 8'h00);
    do_load(3'd4, 8'h80); do_load(3'd5, 8'h01); do_load(3'd6, 8'h7F);
    chk("R7 no err on writable load", {31'd0, err}, 32'd0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][18:16], VEC[i][15:14], VEC[i][13:12], VEC[i][11:10]);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), accw(),
          mk(VEC[i][9], VEC[i][8:1], VEC[i][0], 1'b0));
    end

    // R7 load to fixed pointer ignored, error sticky
    do_load(3'd3, 8'h55);
    chk("R7 err set", {31'd0, err}, 32'd1);
    do_req(3'd3, 2'd3, 2'd0, 2'd1);
    chk("R7 fixed ptr unchanged", accw(), mk(1'b0, 8'h01, 1'b1, 1'b0));
    do_load(3'd7, 8'hAA);
    do_req(3'd7, 2'd1, 2'd0, 2'd0);
    chk("R7 fixed ptr7 unchanged", accw(), mk(1'b1, 8'h00, 1'b1, 1'b0));
    do_load(3'd1, 8'h33);
    chk("R7 err stays", {31'd0, err}, 32'd1);

    // R10 load beats post-modification (ptr0 currently 0x11)
    @(negedge clk);
    req_valid = 1'b1; req_ptr = 3'd0; req_mode = 2'd1; req_mod = 2'd1; req_ofs = 2'd0;
    ld_en = 1'b1; ld_ptr = 3'd0; ld_val = 8'h20;
    @(negedge clk);
    req_valid = 1'b0; ld_en = 1'b0;
    chk("R10 old address issued", accw(), mk(1'b0, 8'h11, 1'b1, 1'b0));
    do_req(3'd0, 2'd0, 2'd0, 2'd0);
    chk("R10 load value kept", accw(), mk(1'b0, 8'h20, 1'b0, 1'b0));

    // R6 R8 R9 double indirection through ptr5 (=0x02) with back-pressure
    @(negedge clk);
    acc_ready = 1'b0;
    req_valid = 1'b1; req_ptr = 3'd5; req_mode = 2'd2; req_mod = 2'd1; req_ofs = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 first access", accw(), mk(1'b1, 8'h02, 1'b1, 1'b0));
    chk("R9 busy and not ready", {30'd0, busy, req_ready}, 32'h2);
    @(negedge clk);
    chk("R8 held under stall", accw(), mk(1'b1, 8'h02, 1'b1, 1'b0));
    acc_ready = 1'b1;
    @(negedge clk);
    chk("R9 waiting for data", {30'd0, acc_valid, busy}, 32'h1);
    ram_rvalid = 1'b1; ram_rdata = 8'h9A;
    @(negedge clk);
    ram_rvalid = 1'b0;
    chk("R6 second access", accw(), mk(1'b1, 8'h9A, 1'b1, 1'b1));
    @(negedge clk);
    chk("R9 idle after second", {30'd0, acc_valid, busy}, 32'h0);
    do_req(3'd5, 2'd0, 2'd0, 2'd0);
    chk("R5 post-inc after double", accw(), mk(1'b1, 8'h03, 1'b0, 1'b0));

    // R6 double through fixed pointer 7, offset 3
    @(negedge clk);
    req_valid = 1'b1; req_ptr = 3'd7; req_mode = 2'd2; req_mod = 2'd0; req_ofs = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 fixed first", accw(), mk(1'b1, 8'h03, 1'b1, 1'b0));
    @(negedge clk);
    ram_rvalid = 1'b1; ram_rdata = 8'h44;
    @(negedge clk);
    ram_rvalid = 1'b0;
    chk("R6 fixed second", accw(), mk(1'b1, 8'h44, 1'b1, 1'b1));
    @(negedge clk);

    // R9 stray read data ignored while idle
    ram_rvalid = 1'b1; ram_rdata = 8'h77;
    @(negedge clk);
    ram_rvalid = 1'b0;
    chk("R9 stray rvalid ignored", {30'd0, acc_valid, busy}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule